// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is a purely combinational adder/subtractor for a configurable data width, 32 bits by default. It takes two operands and an operation select. It returns the wrapped result together with four condition flags: negative, zero, carry and overflow. An execution stage places it in its datapath and registers the outputs in its own pipeline.

Subtraction is formed as the first operand plus the inverted second operand plus one. The carry flag therefore means "no borrow": it is set when the first operand, read as unsigned, is at least as large as the second.

The carry and overflow flags are not taken from the adder's final carry. They are derived from the two operand sign bits and the result sign bit. The internal carry chain can therefore stop one bit short of the top.

The block has no data handshake, because it holds no state. Inputs and outputs are plain levels, and the result is valid in the same cycle the operands are presented.

Top module: `addsub_flags`

## Requirements
- R1: With `op_sub` = 0 (add), `result` equals (`opa` + `opb`) modulo 2^WIDTH.
- R2: With `op_sub` = 1 (subtract), `result` equals (`opa` - `opb`) modulo 2^WIDTH.
- R3: `flag_n` equals bit WIDTH-1 of `result`.
- R4: `flag_z` is 1 exactly when every bit of `result` is 0.
- R5: For an add, `flag_c` is 1 exactly when the unsigned sum of the operands is 2^WIDTH or more.
- R6: For a subtract, `flag_c` is 1 exactly when `opa` >= `opb` as unsigned numbers, meaning no borrow occurs.
- R7: For an add, `flag_v` is 1 exactly when the operands share a sign and the result's sign differs from it, which is the same as the two's-complement sum leaving the signed range.
- R8: For a subtract, `flag_v` is 1 exactly when the operands differ in sign and the result's sign differs from the sign of `opa`.
- R9: The outputs are a function of the present inputs only. A change of `op_sub` alone, with the operands held, switches the outputs between the add and subtract values without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand (minuend for a subtract) |
| opb | input | WIDTH | Second operand (subtrahend for a subtract) |
| op_sub | input | 1 | Operation select: 0 = add, 1 = subtract |
| result | output | WIDTH | Wrapped sum or difference |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (no-borrow for a subtract) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The checker evaluates its immediate assertions whenever the combinational outputs settle. It assumes that all inputs carry known 0/1 values and that the select is one bit wide, so every input pattern is either an add or a subtract. The bench holds each input vector steady across a full clock period and samples one nanosecond after the rising edge. Every checked value is therefore a settled response to defined inputs. A 4-bit copy of the block is swept over every operand pair and both operations. The 32-bit instance receives the sign and magnitude corner cases together with a deterministic pseudo-random set.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } cond_flags_t;
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rhs_in,
  input  addsub_op_e       op,
  output logic [WIDTH-1:0] rhs_eff,
  output logic             carry_in
);
  // Subtraction is lhs + ~rhs + 1.
  always_comb begin
    if (op == OP_SUB) begin
      rhs_eff  = ~rhs_in;
      carry_in = 1'b1;
    end else begin
      rhs_eff  = rhs_in;
      carry_in = 1'b0;
    end
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);
  // The chain stops below the top bit: flags come from the sign bits instead.
  logic [WIDTH-1:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i] = x[i] ^ y[i] ^ chain[i];
    if (i < WIDTH - 1) begin : g_carry
      assign chain[i+1] = (x[i] & y[i]) | (x[i] & chain[i]) | (y[i] & chain[i]);
    end
  end
endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  input  logic [WIDTH-1:0] res,
  input  addsub_op_e       op,
  output cond_flags_t      flags
);
  localparam int MSB = WIDTH - 1;

  logic sa, sb, sr;
  assign sa = lhs[MSB];
  assign sb = rhs[MSB];
  assign sr = res[MSB];

  always_comb begin
    flags.neg  = sr;
    flags.zero = (res == '0);
    if (op == OP_SUB) begin
      flags.carry = (sa & ~sb) | (sa & ~sr) | (~sb & ~sr);
      flags.ovf   = (sa ^ sb) & (sr ^ sa);
    end else begin
      flags.carry = (sa & sb) | (sa & ~sr) | (sb & ~sr);
      flags.ovf   = ~(sa ^ sb) & (sr ^ sa);
    end
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             op_sub,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  addsub_op_e       op;
  logic [WIDTH-1:0] rhs_eff;
  logic             cin;
  logic [WIDTH-1:0] sum;
  cond_flags_t      flags;

  assign op = addsub_op_e'(op_sub);

  addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .rhs_in  (opb),
    .op      (op),
    .rhs_eff (rhs_eff),
    .carry_in(cin)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_add (
    .x  (opa),
    .y  (rhs_eff),
    .cin(cin),
    .sum(sum)
  );

  addsub_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .lhs  (opa),
    .rhs  (opb),
    .res  (sum),
    .op   (op),
    .flags(flags)
  );

  assign result = sum;
  assign flag_n = flags.neg;
  assign flag_z = flags.zero;
  assign flag_c = flags.carry;
  assign flag_v = flags.ovf;
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             op_sub,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);
  logic [WIDTH:0] uwide;
  logic [WIDTH:0] swide;

  always_comb begin
    uwide = {1'b0, opa} + {1'b0, opb};
    swide = op_sub ? ({opa[WIDTH-1], opa} - {opb[WIDTH-1], opb})
                   : ({opa[WIDTH-1], opa} + {opb[WIDTH-1], opb});
    if (!op_sub) begin
      p_add_result_r1: assert (result == opa + opb);
      p_add_carry_r5:  assert (flag_c == uwide[WIDTH]);
      p_add_ovf_r7:    assert (flag_v == (swide[WIDTH] != swide[WIDTH-1]));
    end else begin
      p_sub_result_r2:   assert (result == opa - opb);
      p_sub_noborrow_r6: assert (flag_c == (opa >= opb));
      p_sub_ovf_r8:      assert (flag_v == (swide[WIDTH] != swide[WIDTH-1]));
    end
    p_neg_r3:  assert (flag_n == result[WIDTH-1]);
    p_zero_r4: assert (flag_z == (result == '0));
  end
endmodule

bind addsub_flags addsub_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .opa   (opa),
  .opb   (opb),
  .op_sub(op_sub),
  .result(result),
  .flag_n(flag_n),
  .flag_z(flag_z),
  .flag_c(flag_c),
  .flag_v(flag_v)
);

// File: tb/addsub_flags_tb.sv
`timescale 1ns/1ps
module addsub_flags_tb;
  localparam int W  = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;

  logic [W-1:0]  a, b, r;
  logic          sub, n, z, c, v;
  logic [WS-1:0] sa, sb, sr;
  logic          ssub, sn, szf, sc, sv;

  addsub_flags #(.WIDTH(W)) u_dut (
    .opa(a), .opb(b), .op_sub(sub), .result(r),
    .flag_n(n), .flag_z(z), .flag_c(c), .flag_v(v)
  );

  addsub_flags #(.WIDTH(WS)) u_small (
    .opa(sa), .opb(sb), .op_sub(ssub), .result(sr),
    .flag_n(sn), .flag_z(szf), .flag_c(sc), .flag_v(sv)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Arithmetic reference from the requirements; w is the data width.
  task automatic verify(input int w, input longint x, input longint y, input bit s,
                        input longint res, input bit fn, input bit fz,
                        input bit fc, input bit fv);
    longint mask, sum, er, sx, sy, ss, smax, smin;
    bit ec, ev;
    mask = (longint'(1) << w) - 1;
    sum  = s ? (x - y) : (x + y);
    er   = sum & mask;
    ec   = s ? (x >= y) : (sum > mask);
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    sx   = (x > smax) ? x - (mask + 1) : x;
    sy   = (y > smax) ? y - (mask + 1) : y;
    ss   = s ? (sx - sy) : (sx + sy);
    ev   = (ss > smax) || (ss < smin);
    chk(s ? "R2 result" : "R1 result", res, er);
    chk("R3 flag_n", longint'(fn), (er >> (w - 1)) & 1);
    chk("R4 flag_z", longint'(fz), longint'(er == 0));
    chk(s ? "R6 flag_c" : "R5 flag_c", longint'(fc), longint'(ec));
    chk(s ? "R8 flag_v" : "R7 flag_v", longint'(fv), longint'(ev));
  endtask

  task automatic drive_big(input logic [W-1:0] x, input logic [W-1:0] y, input bit s);
    @(negedge clk);
    a = x; b = y; sub = s;
    @(posedge clk);
    #1;
    verify(W, longint'(x), longint'(y), s, longint'(r), n, z, c, v);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] lfsr;
    a = '0; b = '0; sub = 1'b0;
    sa = '0; sb = '0; ssub = 1'b0;
    @(posedge clk); #1;
    // Idle state: all-zero inputs give a zero result with only Z set (R4).
    chk("R1 idle result", longint'(r), 0);
    chk("R4 idle flag_z", longint'(z), 1);
    chk("R5 idle flag_c", longint'(c), 0);

    // Corner cases on the full-width instance.
    drive_big(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);  // R7: overflow into sign
    drive_big(32'h8000_0000, 32'h0000_0001, 1'b1);  // R8: overflow out of sign
    drive_big(32'h0000_0000, 32'h0000_0000, 1'b1);  // R6: equal -> no borrow
    drive_big(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);  // R5: carry, zero result
    drive_big(32'h8000_0000, 32'h8000_0000, 1'b0);  // R5 R7
    drive_big(32'h0000_0001, 32'h0000_0002, 1'b1);  // R6: borrow
    drive_big(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);  // R8
    drive_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);  // R4 R6

    // R9: flip only the select with the operands held.
    @(negedge clk); a = 32'h0000_0005; b = 32'h0000_0007; sub = 1'b0;
    #2; chk("R9 add value", longint'(r), 12);
    sub = 1'b1;
    #2; chk("R9 sub value", longint'(r), longint'(32'hFFFF_FFFE));
    chk("R9 sub flag_c", longint'(c), 0);

    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive_big(x, lfsr ^ {x[15:0], x[31:16]}, lfsr[3]);
    end

    // Exhaustive sweep of the 4-bit instance.
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          @(negedge clk);
          sa = WS'(x); sb = WS'(y); ssub = s[0];
          @(posedge clk); #1;
          verify(WS, longint'(x), longint'(y), s[0], longint'(sr), sn, szf, sc, sv);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule